// File: doc/BRIEF.md
# Flash Command Front End

This block sits between the CPU bus and the program/erase engine of an on-chip flash controller. Byte writes into the flash range are decoded as commands. Some commands act at once: read array, read status and clear status. Others are sequences that end in a start request to the back-end engine. The block keeps an 8-bit status byte and a read-source flag. The flag tells the bus mux whether a CPU read of the flash range should return array data or the status byte.

The control is a four-state machine:
- `ST_IDLE` accepts a first command byte.
- `ST_CONFIRM` waits for the confirm byte of a two-write erase or lock command.
- `ST_PROGDATA` waits for the single data write of a program command.
- `ST_BUSY` lasts while the engine runs.

The transitions are:
- idle→confirm: a two-write setup byte.
- idle→progdata: the program setup byte.
- confirm→busy: the confirm byte.
- confirm→idle: a cancel byte or a bad byte.
- progdata→busy: any byte.
- busy→idle: the engine's done pulse.

Any pending error in bit 4 or bit 5 blocks the setup commands until software clears status.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset `status` is 0x80, `rd_status` is 0 and `eng_start` is 0.
- R2: `status[7]` is 0 from the cycle in which `eng_start` is high until the clock edge that samples `eng_done`, after which it is 1.
- R3: Status bits 6, 3 and 0 always read 0.
- R4: In idle, writing 0x70 sets `rd_status` to 1 and writing 0xFF clears it. `rd_status_stb` equals `rd_en` AND `rd_status`.
- R5: Every operation start sets `rd_status` to 1. It stays 1, also after completion, until 0xFF is written.
- R6: Writing 0x50 in idle clears status bits 5, 4, 2 and 1.
- R7: In idle, the setup bytes 0x20, 0x77 and 0xA7, each followed by 0xD0, start the engine with `eng_op` = 1, 2 and 3 respectively. The setup byte 0x40 followed by any byte starts the engine with `eng_op` = 0. `eng_start` is a one-cycle pulse in the cycle after the starting write.
- R8: A 0xFF write in the confirm step cancels the command. No start follows, and `rd_status` goes to 0.
- R9: Any confirm byte other than 0xD0 or 0xFF sets bits 5 and 4 and sets `rd_status`. Any idle first byte outside {0xFF, 0x70, 0x50, 0x40, 0x20, 0x77, 0xA7} also sets bits 5 and 4.
- R10: While bit 4 or bit 5 is 1, the setup bytes are ignored and no start is issued.
- R11: While busy, writes are ignored except 0xFF and 0x70, which still clear and set `rd_status`.
- R12: `eng_done` while busy records the completion errors:
    - `eng_fail` sets bit 4 for `eng_op` 0 or 2, and bit 5 for `eng_op` 1 or 3.
    - `eng_wb_err` sets bit 2.
    - `eng_oe_err` sets bit 1.

  The error inputs and `eng_done` have no effect outside busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe into the flash range |
| wr_data | input | 8 | Written byte (command or program data) |
| rd_en | input | 1 | Bus read strobe into the flash range |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Operation failed, sampled with eng_done |
| eng_wb_err | input | 1 | Over-write-back error, sampled with eng_done |
| eng_oe_err | input | 1 | Over-erase error, sampled with eng_done |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_op | output | 2 | Operation type: 0 program, 1 block erase, 2 lock program, 3 erase all |
| rd_status | output | 1 | 1: reads return status; 0: reads return array |
| rd_status_stb | output | 1 | Read strobe qualified to the status source |
| status | output | 8 | Status byte |

## Verification
The assertions assume that the engine raises `eng_done` only after a start, while the block is busy, and for a single cycle per operation. The completion checks also assume that no 0x50 write coincides with `eng_done`. The bench plays the engine itself and raises `eng_done` only a fixed number of cycles after it has seen `eng_start`. It never overlaps a write with the done pulse. The one deliberate out-of-window pulse, sent in idle, is covered by R12 and checked at the status port.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    localparam int CMD_W  = 8;
    localparam int STAT_W = 8;
    localparam int OP_W   = 2;

    localparam logic [CMD_W-1:0] CMD_ARRAY    = 8'hFF;
    localparam logic [CMD_W-1:0] CMD_STATUS   = 8'h70;
    localparam logic [CMD_W-1:0] CMD_CLEAR    = 8'h50;
    localparam logic [CMD_W-1:0] CMD_PROG     = 8'h40;
    localparam logic [CMD_W-1:0] CMD_BLKERASE = 8'h20;
    localparam logic [CMD_W-1:0] CMD_LOCKPROG = 8'h77;
    localparam logic [CMD_W-1:0] CMD_ERASEALL = 8'hA7;
    localparam logic [CMD_W-1:0] CMD_CONFIRM  = 8'hD0;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CONFIRM  = 2'd1,
        ST_PROGDATA = 2'd2,
        ST_BUSY     = 2'd3
    } fcf_state_e;

    // bit 0 of the code marks an erase-class operation
    typedef enum logic [OP_W-1:0] {
        OP_PROG     = 2'd0,
        OP_BLKERASE = 2'd1,
        OP_LOCKPROG = 2'd2,
        OP_ERASEALL = 2'd3
    } fcf_op_e;

    typedef struct packed {
        logic seq_err;
        logic clr_err;
        logic start;
        logic rd_set;
        logic rd_clr;
    } fcf_ctl_t;

endpackage

// File: rtl/fcf_decoder.sv
module fcf_decoder
    import fcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             eng_done,
    input  logic             locked,
    output fcf_ctl_t         ctl,
    output fcf_op_e          op_q,
    output logic             busy,
    output logic             start_q
);

    fcf_state_e state_q, state_d;
    fcf_op_e    op_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PROG;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            start_q <= ctl.start;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    case (wr_data)
                        CMD_ARRAY:  ctl.rd_clr  = 1'b1;
                        CMD_STATUS: ctl.rd_set  = 1'b1;
                        CMD_CLEAR:  ctl.clr_err = 1'b1;
                        CMD_PROG: begin
                            if (!locked) begin
                                state_d = ST_PROGDATA;
                                op_d    = OP_PROG;
                            end
                        end
                        CMD_BLKERASE: begin
                            if (!locked) begin
                                state_d = ST_CONFIRM;
                                op_d    = OP_BLKERASE;
                            end
                        end
                        CMD_LOCKPROG: begin
                            if (!locked) begin
                                state_d = ST_CONFIRM;
                                op_d    = OP_LOCKPROG;
                            end
                        end
                        CMD_ERASEALL: begin
                            if (!locked) begin
                                state_d = ST_CONFIRM;
                                op_d    = OP_ERASEALL;
                            end
                        end
                        default: ctl.seq_err = 1'b1;
                    endcase
                end
            end
            ST_CONFIRM: begin
                if (wr_en) begin
                    if (wr_data == CMD_CONFIRM) begin
                        ctl.start  = 1'b1;
                        ctl.rd_set = 1'b1;
                        state_d    = ST_BUSY;
                    end else if (wr_data == CMD_ARRAY) begin
                        ctl.rd_clr = 1'b1;
                        state_d    = ST_IDLE;
                    end else begin
                        ctl.seq_err = 1'b1;
                        ctl.rd_set  = 1'b1;
                        state_d     = ST_IDLE;
                    end
                end
            end
            ST_PROGDATA: begin
                if (wr_en) begin
                    ctl.start  = 1'b1;
                    ctl.rd_set = 1'b1;
                    state_d    = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (wr_en && wr_data == CMD_ARRAY)  ctl.rd_clr = 1'b1;
                if (wr_en && wr_data == CMD_STATUS) ctl.rd_set = 1'b1;
                if (eng_done) state_d = ST_IDLE;
            end
        endcase
    end

    assign busy = (state_q == ST_BUSY);

endmodule

// File: rtl/fcf_status.sv
module fcf_status
    import fcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clr_err,
    input  logic              seq_err,
    input  logic              done_ev,
    input  fcf_op_e           op,
    input  logic              fail,
    input  logic              wb_err,
    input  logic              oe_err,
    output logic [STAT_W-1:0] status,
    output logic              locked
);

    logic ready_q, erase_q, prog_q, wb_q, oe_q;
    logic erase_class;

    assign erase_class = op[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
            erase_q <= 1'b0;
            prog_q  <= 1'b0;
            wb_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            if (start)        ready_q <= 1'b0;
            else if (done_ev) ready_q <= 1'b1;

            if (clr_err) begin
                erase_q <= 1'b0;
                prog_q  <= 1'b0;
                wb_q    <= 1'b0;
                oe_q    <= 1'b0;
            end else begin
                if (seq_err || (done_ev && fail && erase_class))  erase_q <= 1'b1;
                if (seq_err || (done_ev && fail && !erase_class)) prog_q  <= 1'b1;
                if (done_ev && wb_err) wb_q <= 1'b1;
                if (done_ev && oe_err) oe_q <= 1'b1;
            end
        end
    end

    assign status = {ready_q, 1'b0, erase_q, prog_q, 1'b0, wb_q, oe_q, 1'b0};
    assign locked = erase_q | prog_q;

endmodule

// File: rtl/fcf_rdsel.sv
module fcf_rdsel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stat,
    input  logic clr_stat,
    input  logic rd_en,
    output logic rd_status,
    output logic rd_status_stb
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_status <= 1'b0;
        else if (clr_stat) rd_status <= 1'b0;
        else if (set_stat) rd_status <= 1'b1;
    end

    assign rd_status_stb = rd_en & rd_status;

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import fcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic              eng_wb_err,
    input  logic              eng_oe_err,
    output logic              eng_start,
    output logic [OP_W-1:0]   eng_op,
    output logic              rd_status,
    output logic              rd_status_stb,
    output logic [STAT_W-1:0] status
);

    fcf_ctl_t ctl;
    fcf_op_e  op_q;
    logic     busy;
    logic     locked;

    fcf_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .eng_done (eng_done),
        .locked   (locked),
        .ctl      (ctl),
        .op_q     (op_q),
        .busy     (busy),
        .start_q  (eng_start)
    );

    fcf_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ctl.start),
        .clr_err (ctl.clr_err),
        .seq_err (ctl.seq_err),
        .done_ev (busy & eng_done),
        .op      (op_q),
        .fail    (eng_fail),
        .wb_err  (eng_wb_err),
        .oe_err  (eng_oe_err),
        .status  (status),
        .locked  (locked)
    );

    fcf_rdsel u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_stat      (ctl.rd_set),
        .clr_stat      (ctl.rd_clr),
        .rd_en         (rd_en),
        .rd_status     (rd_status),
        .rd_status_stb (rd_status_stb)
    );

    assign eng_op = op_q;

endmodule

// File: rtl/fcf_checker.sv
module fcf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       eng_done,
    input logic       eng_start,
    input logic       rd_status,
    input logic [7:0] status
);

    // R7: the start request lasts one cycle
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R2: busy is shown while the start request is out
    a_r2_busy_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !status[7]);

    // R2: completion returns the ready bit
    a_r2_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && eng_done) |=> status[7]);

    // R5: a started operation redirects reads to status
    a_r5_status_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> rd_status);

    // R10: a pending error blocks any start
    a_r10_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] || status[5]) |=> !eng_start);

    // R11: the clear command has no effect while busy
    a_r11_busy_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && wr_en && wr_data == 8'h50 && !eng_done)
            |=> (status[5:1] == $past(status[5:1])));

endmodule

bind flash_cmd_front fcf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .rd_status (rd_status),
    .status    (status)
);

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       eng_done = 1'b0;
    logic       eng_fail = 1'b0;
    logic       eng_wb_err = 1'b0;
    logic       eng_oe_err = 1'b0;
    logic       eng_start;
    logic [1:0] eng_op;
    logic       rd_status;
    logic       rd_status_stb;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .eng_done(eng_done), .eng_fail(eng_fail), .eng_wb_err(eng_wb_err),
        .eng_oe_err(eng_oe_err), .eng_start(eng_start), .eng_op(eng_op),
        .rd_status(rd_status), .rd_status_stb(rd_status_stb), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done(input logic f, input logic w, input logic o);
        eng_done = 1'b1;
        eng_fail = f;
        eng_wb_err = w;
        eng_oe_err = o;
        @(negedge clk);
        eng_done = 1'b0;
        eng_fail = 1'b0;
        eng_wb_err = 1'b0;
        eng_oe_err = 1'b0;
    endtask

    // engine model: a short busy count after the start
    task automatic engine(input logic f, input logic w, input logic o);
        repeat (3) @(negedge clk);
        pulse_done(f, w, o);
    endtask

    task automatic to_idle_clean();
        wr(8'h50);
        wr(8'hFF);
    endtask

    function automatic logic [1:0] op_of(input logic [7:0] c);
        case (c)
            8'h20:   return 2'd1;
            8'h77:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] cmds [3];
        cmds[0] = 8'h20; cmds[1] = 8'h77; cmds[2] = 8'hA7;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 8'h80);
        chk("R1 rd_status", {7'd0, rd_status}, 8'h00);
        chk("R1 eng_start", {7'd0, eng_start}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R4 / R7: every first byte from a clean idle
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            logic known, setup, rd_exp;
            bb = b[7:0];
            to_idle_clean();
            wr(bb);
            known  = (bb == 8'hFF || bb == 8'h70 || bb == 8'h50 || bb == 8'h40 ||
                      bb == 8'h20 || bb == 8'h77 || bb == 8'hA7);
            setup  = (bb == 8'h40 || bb == 8'h20 || bb == 8'h77 || bb == 8'hA7);
            rd_exp = (bb == 8'h70);
            chk("R9 first byte status", status, known ? 8'h80 : 8'hB0);
            chk("R4 first byte rd_status", {7'd0, rd_status}, {7'd0, rd_exp});
            chk("R3 reserved bits", status & 8'h49, 8'h00);
            chk("R7 no start on setup", {7'd0, eng_start}, 8'h00);
            if (bb == 8'h40) begin
                wr(8'h5A);
                chk("R7 prog start", {7'd0, eng_start}, 8'h01);
                chk("R7 prog op", {6'd0, eng_op}, 8'h00);
                chk("R2 busy", status, 8'h00);
                engine(1'b0, 1'b0, 1'b0);
                chk("R2 ready after done", status, 8'h80);
            end else if (setup) begin
                wr(8'hFF);
                chk("R8 cancel status", status, 8'h80);
                chk("R8 cancel rd", {7'd0, rd_status}, 8'h00);
            end
        end

        // R8 / R9 / R7: every confirm byte for each two-write command
        foreach (cmds[k]) begin
            for (int b = 0; b < 256; b++) begin
                logic [7:0] bb;
                bb = b[7:0];
                to_idle_clean();
                wr(cmds[k]);
                wr(bb);
                if (bb == 8'hD0) begin
                    chk("R7 confirm start", {7'd0, eng_start}, 8'h01);
                    chk("R7 confirm op", {6'd0, eng_op}, {6'd0, op_of(cmds[k])});
                    chk("R2 busy after confirm", status, 8'h00);
                    @(negedge clk);
                    chk("R7 start one cycle", {7'd0, eng_start}, 8'h00);
                    engine(1'b0, 1'b0, 1'b0);
                    chk("R5 status kept after done", {7'd0, rd_status}, 8'h01);
                end else if (bb == 8'hFF) begin
                    chk("R8 cancel start", {7'd0, eng_start}, 8'h00);
                    chk("R8 cancel status", status, 8'h80);
                    chk("R8 cancel rd", {7'd0, rd_status}, 8'h00);
                end else begin
                    chk("R9 bad confirm status", status, 8'hB0);
                    chk("R9 bad confirm rd", {7'd0, rd_status}, 8'h01);
                    chk("R9 bad confirm start", {7'd0, eng_start}, 8'h00);
                end
            end
        end

        // R12: completion error mapping per operation class
        to_idle_clean();
        wr(8'h40); wr(8'h11); engine(1'b1, 1'b0, 1'b0);
        chk("R12 program fail", status, 8'h90);
        wr(8'h50);
        chk("R6 clear", status, 8'h80);
        wr(8'h20); wr(8'hD0); engine(1'b1, 1'b0, 1'b0);
        chk("R12 erase fail", status, 8'hA0);
        wr(8'h50);
        wr(8'h77); wr(8'hD0); engine(1'b1, 1'b0, 1'b0);
        chk("R12 lock fail", status, 8'h90);
        wr(8'h50);
        wr(8'hA7); wr(8'hD0); engine(1'b0, 1'b0, 1'b1);
        chk("R12 over-erase", status, 8'h82);
        wr(8'h50);
        wr(8'h40); wr(8'h22); engine(1'b0, 1'b1, 1'b0);
        chk("R12 over-write-back", status, 8'h84);
        wr(8'h50);
        chk("R6 clear wb", status, 8'h80);
        @(negedge clk);
        pulse_done(1'b1, 1'b1, 1'b1);
        chk("R12 done ignored in idle", status, 8'h80);

        // R10: locked after a sequence error
        to_idle_clean();
        wr(8'h33);
        chk("R9 unknown byte", status, 8'hB0);
        wr(8'h40);
        wr(8'h12);
        chk("R10 prog setup ignored", {7'd0, eng_start}, 8'h00);
        chk("R10 status kept", status, 8'hB0);
        wr(8'h20);
        wr(8'hD0);
        chk("R10 erase ignored", {7'd0, eng_start}, 8'h00);
        chk("R10 still ready", status, 8'hB0);

        // R11: writes while busy
        to_idle_clean();
        wr(8'h40); wr(8'h01);
        wr(8'h20);
        chk("R11 busy holds", status, 8'h00);
        wr(8'hFF);
        chk("R11 FF in busy", {7'd0, rd_status}, 8'h00);
        wr(8'h70);
        chk("R11 70 in busy", {7'd0, rd_status}, 8'h01);
        rd_en = 1'b1;
        #1;
        chk("R4 strobe qualified", {7'd0, rd_status_stb}, 8'h01);
        pulse_done(1'b0, 1'b0, 1'b0);
        wr(8'hD0);
        chk("R11 setup was ignored", status, 8'hB0);
        wr(8'h50); wr(8'hFF);
        #1;
        chk("R4 strobe off in array", {7'd0, rd_status_stb}, 8'h00);
        rd_en = 1'b0;

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule